// File: doc/BRIEF.md
# Secure Clock Bypass Handshake Controller

This block decides when the clocks of a chip move over to an external bypass source, and it runs the request and acknowledge exchange for that move. Every control word it takes or gives is a redundant 4-bit encoded value, not a single bit. A glitch or a fault on such a word yields a value that matches no valid code. The block treats any such value as the safe, inactive state.

It has two paths. The all-clock path is combinational: a debug-enable word and a software external-clock select are decoded, and the result is registered into an all-clock bypass request. The lifecycle path starts with a bypass request that arrives from another clock domain. That request is resynchronized, then forwarded as an I/O clock bypass request. When the I/O clock source confirms the switch and both clock dividers report that they have stepped down, the synchronized request is echoed back as the lifecycle acknowledge.

Top module: `clk_bypass_ctrl`

## Requirements
- R1: The all-clock request `all_byp_req` is 4'h6 (True) on the rising edge after an edge where `dbg_en` is 4'hA (On) and `ext_sel` is 4'h6 (True).
- R2: When either of those codes does not match exactly, `all_byp_req` is 4'h9 (False) after the next edge. This includes every invalid value, such as 4'h0, 4'hF and the opposite code.
- R3: When `lc_byp_req` is held at 4'hA (On), `io_byp_req` becomes 4'h6 at the third rising edge. It is still False after the second edge. The window is two synchronizer flops plus one output register.
- R4: When `lc_byp_req` is any value other than 4'hA, including invalid codes, `io_byp_req` is 4'h9 (False) three edges later.
- R5: `lc_byp_ack` is 4'h5 (Off) after the next edge whenever either bit of `div_step_ack` is 0 or `io_byp_ack` is not exactly 4'h6.
- R6: While both bits of `div_step_ack` are 1 and `io_byp_ack` is 4'h6, `lc_byp_ack` equals the `lc_byp_req` value presented three edges earlier. It is therefore still the old value after two edges.
- R7: `div_step_ack` is a 2-bit vector, one bit per divider. The acknowledge passes only when bit 0 and bit 1 are both 1.
- R8: While `rst_n` is low, `all_byp_req` and `io_byp_req` are 4'h9 (False) and `lc_byp_ack` is 4'h5 (Off).
- R9: An invalid code on any encoded input never makes `all_byp_req` or `io_byp_req` 4'h6, and never makes `lc_byp_ack` 4'hA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 4 | Debug-enable, lifecycle code (On 4'hA, Off 4'h5) |
| ext_sel | input | 4 | Software external-clock select, boolean code (True 4'h6, False 4'h9) |
| lc_byp_req | input | 4 | Lifecycle bypass request from another domain, lifecycle code |
| io_byp_ack | input | 4 | I/O clock source bypass acknowledge, boolean code |
| div_step_ack | input | 2 | Synchronized step-down acknowledges, one bit per divider |
| all_byp_req | output | 4 | All-clock bypass request, boolean code |
| io_byp_req | output | 4 | I/O clock bypass request, boolean code |
| lc_byp_ack | output | 4 | Lifecycle bypass acknowledge, lifecycle code |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and two divider acknowledges. With these values the exact three-edge request latency can be checked, and each divider bit can be withheld on its own. Invalid codes are swept on every encoded input (4'h0, 4'hF, the opposite code and odd values) to confirm that no output ever reaches its active code. The acknowledge echo is sampled one edge early as well as on time, so that a shift in latency in either direction is caught.

// File: rtl/clkbyp_pkg.sv
package clkbyp_pkg;

    localparam int ENC_W = 4;

    typedef logic [ENC_W-1:0] enc_t;

    localparam enc_t BOOL_TRUE  = 4'h6;
    localparam enc_t BOOL_FALSE = 4'h9;
    localparam enc_t LC_ON      = 4'hA;
    localparam enc_t LC_OFF     = 4'h5;

    function automatic logic is_true(enc_t v);
        return v == BOOL_TRUE;
    endfunction

    function automatic logic is_on(enc_t v);
        return v == LC_ON;
    endfunction

endpackage

// File: rtl/clkbyp_sync.sv
module clkbyp_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign q = stage_q[STAGES-1];

    // R3: each flop takes the value its predecessor held one edge before
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chk
            a_r3_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
                stage_q[g] == $past(stage_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/clkbyp_ack_gate.sv
module clkbyp_ack_gate
    import clkbyp_pkg::*;
#(
    parameter int N_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DIV-1:0] step_acks,
    input  enc_t             io_ack,
    input  enc_t             req_sync,
    output enc_t             ack
);

    typedef struct packed {
        enc_t ack;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     pass;

    always_comb begin
        pass   = (&step_acks) && is_true(io_ack);
        st_d   = st_q;
        st_d.ack = pass ? req_sync : LC_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ack <= LC_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack = st_q.ack;

    // R5, R7: a missing divider bit or a non-True I/O acknowledge forces Off
    a_r5_ack_off: assert property (@(posedge clk) disable iff (!rst_n)
        !((&step_acks) && io_ack == BOOL_TRUE) |=> ack == LC_OFF);

    // R6: with all acknowledges present, the synchronized request is echoed
    a_r6_ack_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ((&step_acks) && io_ack == BOOL_TRUE) |=> ack == $past(req_sync));

endmodule

// File: rtl/clk_bypass_ctrl.sv
module clk_bypass_ctrl
    import clkbyp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       dbg_en,
    input  logic [3:0]       ext_sel,
    input  logic [3:0]       lc_byp_req,
    input  logic [3:0]       io_byp_ack,
    input  logic [N_DIV-1:0] div_step_ack,
    output logic [3:0]       all_byp_req,
    output logic [3:0]       io_byp_req,
    output logic [3:0]       lc_byp_ack
);

    typedef struct packed {
        enc_t all_req;
        enc_t io_req;
    } req_st_t;

    req_st_t st_d, st_q;
    enc_t    lc_req_sync;

    clkbyp_sync #(
        .W       (ENC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LC_OFF)
    ) i_lc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lc_byp_req),
        .q     (lc_req_sync)
    );

    always_comb begin
        st_d = st_q;
        st_d.all_req = (is_on(dbg_en) && is_true(ext_sel)) ? BOOL_TRUE : BOOL_FALSE;
        st_d.io_req  = is_on(lc_req_sync) ? BOOL_TRUE : BOOL_FALSE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.all_req <= BOOL_FALSE;
            st_q.io_req  <= BOOL_FALSE;
        end else begin
            st_q <= st_d;
        end
    end

    clkbyp_ack_gate #(
        .N_DIV (N_DIV)
    ) i_ack_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_acks (div_step_ack),
        .io_ack    (io_byp_ack),
        .req_sync  (lc_req_sync),
        .ack       (lc_byp_ack)
    );

    assign all_byp_req = st_q.all_req;
    assign io_byp_req  = st_q.io_req;

    // Edges since reset, for assertions that look back several cycles
    logic [2:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 3'd7) begin
            warm_q <= warm_q + 3'd1;
        end
    end

    // R1
    a_r1_all_req_true: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en == LC_ON && ext_sel == BOOL_TRUE) |=> all_byp_req == BOOL_TRUE);

    // R2, R9
    a_r2_all_req_false: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en != LC_ON || ext_sel != BOOL_TRUE) |=> all_byp_req == BOOL_FALSE);

    // R9: outputs only ever carry valid codes
    a_r9_valid_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (all_byp_req == BOOL_TRUE || all_byp_req == BOOL_FALSE) &&
        (io_byp_req == BOOL_TRUE || io_byp_req == BOOL_FALSE));

    generate
        if (SYNC_STAGES == 2) begin : g_lat
            // R3
            a_r3_io_req_true: assert property (@(posedge clk) disable iff (!rst_n)
                lc_byp_req == LC_ON |=> ##2 io_byp_req == BOOL_TRUE);
            // R4
            a_r4_io_req_false: assert property (@(posedge clk) disable iff (!rst_n)
                lc_byp_req != LC_ON |=> ##2 io_byp_req == BOOL_FALSE);
            // R6
            a_r6_ack_echo: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 3'd3 && (&div_step_ack) && io_byp_ack == BOOL_TRUE)
                |=> lc_byp_ack == $past(lc_byp_req, 3));
        end
    endgenerate

endmodule

// File: tb/test_clk_bypass_ctrl.sv
module test_clk_bypass_ctrl;

    localparam logic [3:0] T = 4'h6, F = 4'h9, ON = 4'hA, OFF = 4'h5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dbg_en = OFF, ext_sel = F, lc_byp_req = OFF, io_byp_ack = F;
    logic [1:0] div_step_ack = 2'b00;
    logic [3:0] all_byp_req, io_byp_req, lc_byp_ack;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    clk_bypass_ctrl i_clk_bypass_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_en       (dbg_en),
        .ext_sel      (ext_sel),
        .lc_byp_req   (lc_byp_req),
        .io_byp_ack   (io_byp_ack),
        .div_step_ack (div_step_ack),
        .all_byp_req  (all_byp_req),
        .io_byp_req   (io_byp_req),
        .lc_byp_ack   (lc_byp_ack)
    );

    task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        tick(2);
        check("R8", "all_byp_req in reset", all_byp_req, F);
        check("R8", "io_byp_req in reset", io_byp_req, F);
        check("R8", "lc_byp_ack in reset", lc_byp_ack, OFF);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic t_all_req();
        logic [3:0] bad_dbg [5] = '{4'h0, 4'hF, OFF, 4'hB, 4'h2};
        logic [3:0] bad_sel [5] = '{4'h0, 4'hF, F, 4'h7, 4'hE};
        dbg_en = ON; ext_sel = T;
        tick(1);
        check("R1", "all_byp_req on valid pair", all_byp_req, T);
        for (int i = 0; i < 5; i++) begin
            dbg_en = bad_dbg[i]; ext_sel = T;
            tick(1);
            check("R2", "all_byp_req with bad dbg_en", all_byp_req, F);
            dbg_en = ON; ext_sel = bad_sel[i];
            tick(1);
            check("R9", "all_byp_req with bad ext_sel", all_byp_req, F);
        end
        dbg_en = OFF; ext_sel = F;
        tick(1);
        check("R2", "all_byp_req both off", all_byp_req, F);
    endtask

    task automatic t_io_req();
        logic [3:0] bad_lc [4] = '{4'h0, 4'hF, 4'hB, T};
        lc_byp_req = ON;
        tick(2);
        check("R3", "io_byp_req after two edges", io_byp_req, F);
        tick(1);
        check("R3", "io_byp_req after three edges", io_byp_req, T);
        lc_byp_req = OFF;
        tick(2);
        check("R4", "io_byp_req two edges after Off", io_byp_req, T);
        tick(1);
        check("R4", "io_byp_req three edges after Off", io_byp_req, F);
        for (int i = 0; i < 4; i++) begin
            lc_byp_req = ON;
            tick(3);
            lc_byp_req = bad_lc[i];
            tick(3);
            check("R9", "io_byp_req with invalid lc code", io_byp_req, F);
        end
        lc_byp_req = OFF;
        tick(3);
    endtask

    task automatic t_ack();
        logic [3:0] bad_io [4] = '{4'h0, 4'hF, F, 4'h7};
        div_step_ack = 2'b11; io_byp_ack = T; lc_byp_req = OFF;
        tick(3);
        check("R6", "ack echoes Off", lc_byp_ack, OFF);
        lc_byp_req = ON;
        tick(2);
        check("R6", "ack still old after two edges", lc_byp_ack, OFF);
        tick(1);
        check("R6", "ack echoes On after three edges", lc_byp_ack, ON);
        div_step_ack = 2'b01;
        tick(1);
        check("R7", "ack with divider bit1 missing", lc_byp_ack, OFF);
        div_step_ack = 2'b10;
        tick(1);
        check("R7", "ack with divider bit0 missing", lc_byp_ack, OFF);
        div_step_ack = 2'b00;
        tick(1);
        check("R5", "ack with no divider acks", lc_byp_ack, OFF);
        div_step_ack = 2'b11;
        tick(1);
        check("R6", "ack restored", lc_byp_ack, ON);
        for (int i = 0; i < 4; i++) begin
            io_byp_ack = bad_io[i];
            tick(1);
            check("R5", "ack with non-True io ack", lc_byp_ack, OFF);
        end
        io_byp_ack = T; lc_byp_req = 4'hB;
        tick(3);
        check("R9", "ack never On from invalid lc code", lc_byp_ack == ON ? 4'h1 : 4'h0, 4'h0);
        lc_byp_req = OFF; io_byp_ack = F; div_step_ack = 2'b00;
        tick(3);
    endtask

    initial begin
        t_reset();
        t_all_req();
        t_io_req();
        t_ack();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule